// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block keeps coherence state for a small direct-mapped cache that sits on a shared bus using write-invalidate snooping. Each entry holds a tag, one line of data and a three-valued coherence state: Invalid, Shared (read-only) or Exclusive (read/write, dirty). The processor side accepts one read or write at a time. Hits that need no bus traffic complete locally. Misses, and writes to lines that are not Exclusive, send a bus command through a request/grant handshake, and the processor is held busy until that command completes.

The snoop side compares each bus request issued by another cache against the tag array in the cycle the request appears. An Exclusive owner that snoops a read miss or a write miss flags an abort of the memory access and presents its dirty line for write-back. After a read miss the owner keeps the line as Shared. After a write miss it drops the line to Invalid. A snooped write miss also invalidates a Shared copy. A write to a Shared line is sent as a full write miss. There is no separate upgrade command.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every entry is Invalid, `cpu_busy`, `bus_req` and `snp_abort` are 0, and the first access to any address produces a bus command.
- R2: A processor read that misses issues `bus_cmd`=1 (read miss) with `bus_addr` equal to the request address. It completes with `cpu_rdata` equal to `bus_rdata` of the fill, and leaves the line Shared.
- R3: A read that hits a Shared or Exclusive line, and a write that hits an Exclusive line, complete with no bus request. A read returns the stored line, and the last written data is what a later read returns.
- R4: A processor write to an Invalid line, or to a line holding a different tag, issues `bus_cmd`=2 (write miss) and leaves the line Exclusive with the written data.
- R5: A processor write to a Shared line with a matching tag issues a full write miss (`bus_cmd`=2) with no upgrade command, and leaves the line Exclusive.
- R6: A miss whose victim entry is Exclusive with a different tag first issues `bus_cmd`=3 (write-back), carrying the victim's line address and data, and then issues the miss. A Shared victim is not written back.
- R7: A snooped write miss (`snp_cmd`=2) that hits a Shared line makes it Invalid without an abort. A snooped read miss (`snp_cmd`=1) on a Shared line, and any snoop whose tag does not match, leave the line as it was.
- R8: A snooped read miss that hits an Exclusive line raises `snp_abort` in the following cycle, with `snp_flush_data` equal to the line, and leaves the line Shared.
- R9: A snooped write miss that hits an Exclusive line raises `snp_abort` in the following cycle, with `snp_flush_data` equal to the line, and leaves the line Invalid.
- R10: `bus_req` is held, with `bus_cmd` and `bus_addr` stable, until `bus_gnt`. `cpu_busy` is 1 from the cycle after a request is accepted until the cycle `cpu_done` pulses, and only one request is outstanding.
- R11: A snoop that hits the entry a pending processor request is looking up takes priority. The lookup is retried afterwards against the updated state, so a read of a Shared line invalidated by that snoop becomes a read miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle processor request strobe, accepted when not busy |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_wdata | input | LINE_W | Full-line write data |
| cpu_busy | output | 1 | Request in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | LINE_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the bus command |
| bus_wdata | output | LINE_W | Write-back data |
| bus_done | input | 1 | Granted transaction complete |
| bus_rdata | input | LINE_W | Fill data, valid with bus_done |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_cmd | input | 2 | 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_abort | output | 1 | Abort memory access; this cache supplies the line |
| snp_flush_data | output | LINE_W | Dirty line supplied with snp_abort |

## Verification
The bench builds the block with ADDR_W=8, INDEX_W=2 and LINE_W=32, so there are only four entries. Addresses 0x05, 0x09 and 0x0D then all map to one entry, and 0x02, 0x06 and 0x0A to another. With a handful of addresses the bench can reach replacement of Exclusive and Shared victims, snoops with a matching and a non-matching tag, and a snoop landing on the entry under lookup. The bus responder waits two cycles before each grant, which exposes the request-hold behaviour.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_RDMISS = 2'd1,
    CMD_WRMISS = 2'd2,
    CMD_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    F_IDLE   = 3'd0,
    F_LOOK   = 3'd1,
    F_WBREQ  = 3'd2,
    F_WBWAIT = 3'd3,
    F_MREQ   = 3'd4,
    F_MWAIT  = 3'd5
  } fsm_e;
endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
  import msi_pkg::*;
#(
  parameter int INDEX_W = 6,
  parameter int TAG_W   = 26,
  parameter int LINE_W  = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [INDEX_W-1:0]  p_idx,
  output logic [TAG_W-1:0]    p_tag_rd,
  output logic [LINE_W-1:0]   p_data_rd,
  output line_st_e            p_st_rd,
  input  logic                p_we_tag,
  input  logic [TAG_W-1:0]    p_tag_wr,
  input  logic                p_we_data,
  input  logic [LINE_W-1:0]   p_data_wr,
  input  logic                p_we_st,
  input  line_st_e            p_st_wr,
  input  logic [INDEX_W-1:0]  s_idx,
  output logic [TAG_W-1:0]    s_tag_rd,
  output logic [LINE_W-1:0]   s_data_rd,
  output line_st_e            s_st_rd,
  input  logic                s_we_st,
  input  line_st_e            s_st_wr
);
  localparam int LINES = 1 << INDEX_W;

  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [LINE_W-1:0] data_mem [LINES];
  line_st_e          st_q     [LINES];

  // tag and data arrays carry no reset so they map onto RAM
  always_ff @(posedge clk) begin
    if (p_we_tag)  tag_mem[p_idx]  <= p_tag_wr;
    if (p_we_data) data_mem[p_idx] <= p_data_wr;
  end

  // state array: snoop update first, processor update wins on a clash
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else begin
      if (s_we_st) st_q[s_idx] <= s_st_wr;
      if (p_we_st) st_q[p_idx] <= p_st_wr;
    end
  end

  assign p_tag_rd  = tag_mem[p_idx];
  assign p_data_rd = data_mem[p_idx];
  assign p_st_rd   = st_q[p_idx];
  assign s_tag_rd  = tag_mem[s_idx];
  assign s_data_rd = data_mem[s_idx];
  assign s_st_rd   = st_q[s_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6,
  parameter int LINE_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       snp_valid,
  input  logic [1:0]                 snp_cmd,
  input  logic [ADDR_W-1:0]          snp_addr,
  output logic [INDEX_W-1:0]         s_idx,
  input  logic [ADDR_W-INDEX_W-1:0]  s_tag_rd,
  input  logic [LINE_W-1:0]          s_data_rd,
  input  line_st_e                   s_st_rd,
  output logic                       s_we_st,
  output line_st_e                   s_st_wr,
  output logic                       snoop_hit,
  output logic                       snp_abort,
  output logic [LINE_W-1:0]          snp_flush_data
);
  logic is_rd, is_wr, owner;

  assign s_idx     = snp_addr[INDEX_W-1:0];
  assign is_rd     = (snp_cmd == CMD_RDMISS);
  assign is_wr     = (snp_cmd == CMD_WRMISS);
  assign snoop_hit = snp_valid && (is_rd || is_wr) && (s_st_rd != LN_INV)
                     && (s_tag_rd == snp_addr[ADDR_W-1:INDEX_W]);
  assign owner     = snoop_hit && (s_st_rd == LN_EXC);

  always_comb begin
    s_we_st = snoop_hit && (owner || is_wr);
    s_st_wr = (owner && is_rd) ? LN_SHR : LN_INV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_abort      <= 1'b0;
      snp_flush_data <= '0;
    end else begin
      snp_abort <= owner;
      if (owner) snp_flush_data <= s_data_rd;
    end
  end
endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6,
  parameter int LINE_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [LINE_W-1:0]          cpu_wdata,
  output logic                       cpu_busy,
  output logic                       cpu_done,
  output logic [LINE_W-1:0]          cpu_rdata,
  output logic                       bus_req,
  input  logic                       bus_gnt,
  output logic [1:0]                 bus_cmd,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic [LINE_W-1:0]          bus_wdata,
  input  logic                       bus_done,
  input  logic [LINE_W-1:0]          bus_rdata,
  output logic [INDEX_W-1:0]         p_idx,
  input  logic [ADDR_W-INDEX_W-1:0]  p_tag_rd,
  input  logic [LINE_W-1:0]          p_data_rd,
  input  line_st_e                   p_st_rd,
  output logic                       p_we_tag,
  output logic [ADDR_W-INDEX_W-1:0]  p_tag_wr,
  output logic                       p_we_data,
  output logic [LINE_W-1:0]          p_data_wr,
  output logic                       p_we_st,
  output line_st_e                   p_st_wr,
  input  logic                       snoop_hit,
  input  logic [INDEX_W-1:0]         snoop_idx
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  fsm_e              st_q;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [LINE_W-1:0] req_wdata;
  logic [TAG_W-1:0]  req_tag;
  logic              tag_hit, conflict, local_ok, dirty_victim;
  logic [1:0]        miss_cmd;

  assign p_idx        = req_addr[INDEX_W-1:0];
  assign req_tag      = req_addr[ADDR_W-1:INDEX_W];
  assign tag_hit      = (p_st_rd != LN_INV) && (p_tag_rd == req_tag);
  assign conflict     = snoop_hit && (snoop_idx == p_idx);
  assign local_ok     = tag_hit && (!req_we || p_st_rd == LN_EXC);
  assign dirty_victim = (p_st_rd == LN_EXC) && !tag_hit;
  assign miss_cmd     = req_we ? CMD_WRMISS : CMD_RDMISS;

  always_comb begin
    p_we_tag  = 1'b0;
    p_tag_wr  = req_tag;
    p_we_data = 1'b0;
    p_data_wr = req_wdata;
    p_we_st   = 1'b0;
    p_st_wr   = LN_INV;
    unique case (st_q)
      F_LOOK: begin
        if (!conflict && local_ok && req_we) p_we_data = 1'b1;
      end
      F_WBWAIT: begin
        if (bus_done) p_we_st = 1'b1;
      end
      F_MWAIT: begin
        if (bus_done) begin
          p_we_tag  = 1'b1;
          p_we_data = 1'b1;
          p_data_wr = req_we ? req_wdata : bus_rdata;
          p_we_st   = 1'b1;
          p_st_wr   = req_we ? LN_EXC : LN_SHR;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= F_IDLE;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      cpu_busy  <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      unique case (st_q)
        F_IDLE: begin
          if (cpu_req) begin
            req_we    <= cpu_we;
            req_addr  <= cpu_addr;
            req_wdata <= cpu_wdata;
            cpu_busy  <= 1'b1;
            st_q      <= F_LOOK;
          end
        end
        F_LOOK: begin
          if (!conflict) begin
            if (local_ok) begin
              cpu_done  <= 1'b1;
              cpu_busy  <= 1'b0;
              cpu_rdata <= req_we ? req_wdata : p_data_rd;
              st_q      <= F_IDLE;
            end else if (dirty_victim) begin
              bus_req   <= 1'b1;
              bus_cmd   <= CMD_WBACK;
              bus_addr  <= {p_tag_rd, p_idx};
              bus_wdata <= p_data_rd;
              st_q      <= F_WBREQ;
            end else begin
              bus_req  <= 1'b1;
              bus_cmd  <= miss_cmd;
              bus_addr <= req_addr;
              st_q     <= F_MREQ;
            end
          end
        end
        F_WBREQ: begin
          if (bus_gnt) begin
            bus_req <= 1'b0;
            bus_cmd <= CMD_NONE;
            st_q    <= F_WBWAIT;
          end
        end
        F_WBWAIT: begin
          if (bus_done) begin
            bus_req  <= 1'b1;
            bus_cmd  <= miss_cmd;
            bus_addr <= req_addr;
            st_q     <= F_MREQ;
          end
        end
        F_MREQ: begin
          if (bus_gnt) begin
            bus_req <= 1'b0;
            bus_cmd <= CMD_NONE;
            st_q    <= F_MWAIT;
          end
        end
        F_MWAIT: begin
          if (bus_done) begin
            cpu_done  <= 1'b1;
            cpu_busy  <= 1'b0;
            cpu_rdata <= req_we ? req_wdata : bus_rdata;
            st_q      <= F_IDLE;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6,
  parameter int LINE_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [LINE_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [LINE_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LINE_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [LINE_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [LINE_W-1:0] snp_flush_data
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] p_idx, s_idx;
  logic [TAG_W-1:0]   p_tag_rd, p_tag_wr, s_tag_rd;
  logic [LINE_W-1:0]  p_data_rd, p_data_wr, s_data_rd;
  line_st_e           p_st_rd, p_st_wr, s_st_rd, s_st_wr;
  logic               p_we_tag, p_we_data, p_we_st, s_we_st, snoop_hit;

  msi_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst(rst),
    .p_idx(p_idx), .p_tag_rd(p_tag_rd), .p_data_rd(p_data_rd), .p_st_rd(p_st_rd),
    .p_we_tag(p_we_tag), .p_tag_wr(p_tag_wr), .p_we_data(p_we_data),
    .p_data_wr(p_data_wr), .p_we_st(p_we_st), .p_st_wr(p_st_wr),
    .s_idx(s_idx), .s_tag_rd(s_tag_rd), .s_data_rd(s_data_rd), .s_st_rd(s_st_rd),
    .s_we_st(s_we_st), .s_st_wr(s_st_wr)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .LINE_W(LINE_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .s_idx(s_idx), .s_tag_rd(s_tag_rd), .s_data_rd(s_data_rd), .s_st_rd(s_st_rd),
    .s_we_st(s_we_st), .s_st_wr(s_st_wr), .snoop_hit(snoop_hit),
    .snp_abort(snp_abort), .snp_flush_data(snp_flush_data)
  );

  msi_proc_fsm #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .LINE_W(LINE_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .p_idx(p_idx), .p_tag_rd(p_tag_rd), .p_data_rd(p_data_rd), .p_st_rd(p_st_rd),
    .p_we_tag(p_we_tag), .p_tag_wr(p_tag_wr), .p_we_data(p_we_data),
    .p_data_wr(p_data_wr), .p_we_st(p_we_st), .p_st_wr(p_st_wr),
    .snoop_hit(snoop_hit), .snoop_idx(s_idx)
  );
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic              snp_abort,
  input logic [LINE_W-1:0] snp_flush_data
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bus_req && !cpu_busy && !snp_abort));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> bus_req);

  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> ($stable(bus_cmd) && $stable(bus_addr)));

  // R10
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (cpu_busy && bus_cmd != 2'd0));

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> ($past(cpu_busy) && !cpu_busy));

  // R10
  busy_starts_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_busy) |-> $past(cpu_req));

  // R8
  abort_after_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snp_abort |-> $past(snp_valid));

  // R9
  flush_held_chk: assert property (@(posedge clk) disable iff (rst)
    !snp_abort |=> (snp_abort || $stable(snp_flush_data)));
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .snp_valid(snp_valid), .snp_abort(snp_abort), .snp_flush_data(snp_flush_data)
);

// File: tb/tb_msi_line_ctrl.sv
`timescale 1ns/1ps
module tb_msi_line_ctrl;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int LW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [LW-1:0] cpu_wdata = '0;
  logic          cpu_busy, cpu_done;
  logic [LW-1:0] cpu_rdata;
  logic          bus_req, bus_gnt = 1'b0, bus_done = 1'b0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [LW-1:0] bus_wdata, bus_rdata = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = 2'd0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_abort;
  logic [LW-1:0] snp_flush_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic [LW-1:0] data;
    string         req;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  msi_line_ctrl #(.ADDR_W(AW), .INDEX_W(IW), .LINE_W(LW)) dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
    .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_abort(snp_abort), .snp_flush_data(snp_flush_data)
  );

  function automatic logic [LW-1:0] fill(input logic [AW-1:0] a);
    return 32'h5A00_0000 | {24'h0, a};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] c, input logic [AW-1:0] a,
                          input logic [LW-1:0] d, input string req);
    exp_t e;
    e.cmd = c; e.addr = a; e.data = d; e.req = req;
    expq.push_back(e);
  endtask

  // bus responder and monitor: pops expected commands, grants after a delay
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !rst) begin
        exp_t e;
        logic [1:0]    c0;
        logic [AW-1:0] a0;
        c0 = bus_cmd; a0 = bus_addr;
        if (expq.size() == 0) begin
          check("R3", "unexpected bus command", {30'h0, c0}, 32'h0);
        end else begin
          e = expq.pop_front();
          check(e.req, "bus_cmd", {30'h0, c0}, {30'h0, e.cmd});
          check(e.req, "bus_addr", {24'h0, a0}, {24'h0, e.addr});
          if (e.cmd == 2'd3) check(e.req, "write-back data", bus_wdata, e.data);
        end
        repeat (2) begin
          @(negedge clk);
          check("R10", "bus_req held before grant", {31'h0, bus_req}, 32'h1);
          check("R10", "bus_cmd stable before grant", {30'h0, bus_cmd}, {30'h0, c0});
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        @(negedge clk);
        bus_done  = 1'b1;
        bus_rdata = fill(a0);
        @(negedge clk);
        bus_done = 1'b0;
      end
    end
  end

  // processor operation, optionally with a snoop in the lookup cycle
  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [LW-1:0] wd,
                        input bit chk_rd, input logic [LW-1:0] exp_rd, input string req,
                        input bit with_snp = 1'b0, input logic [1:0] sc = 2'd0,
                        input logic [AW-1:0] sa = '0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    if (with_snp) begin
      snp_valid = 1'b1; snp_cmd = sc; snp_addr = sa;
    end
    check("R10", "busy after accept", {31'h0, cpu_busy}, 32'h1);
    @(negedge clk);
    snp_valid = 1'b0;
    while (!cpu_done) @(negedge clk);
    if (chk_rd) check(req, "cpu_rdata", cpu_rdata, exp_rd);
    check(req, "pending bus commands left", expq.size(), 0);
  endtask

  task automatic snoop(input logic [1:0] sc, input logic [AW-1:0] sa,
                       input logic exp_ab, input logic [LW-1:0] exp_d, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = sc; snp_addr = sa;
    @(negedge clk);
    snp_valid = 1'b0;
    check(req, "snp_abort", {31'h0, snp_abort}, {31'h0, exp_ab});
    if (exp_ab) check(req, "snp_flush_data", snp_flush_data, exp_d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "cpu_busy after reset", {31'h0, cpu_busy}, 32'h0);
    check("R1", "bus_req after reset", {31'h0, bus_req}, 32'h0);
    check("R1", "snp_abort after reset", {31'h0, snp_abort}, 32'h0);

    // R1 / R2: first read misses
    push_exp(2'd1, 8'h05, '0, "R2");
    cpu_op(1'b0, 8'h05, '0, 1'b1, fill(8'h05), "R2");
    // R3: read hit in Shared
    cpu_op(1'b0, 8'h05, '0, 1'b1, fill(8'h05), "R3");
    // R5: write to Shared issues a write miss
    push_exp(2'd2, 8'h05, '0, "R5");
    cpu_op(1'b1, 8'h05, 32'hD1D1_0001, 1'b0, '0, "R5");
    cpu_op(1'b0, 8'h05, '0, 1'b1, 32'hD1D1_0001, "R3");
    // R3: write hit in Exclusive
    cpu_op(1'b1, 8'h05, 32'hD2D2_0002, 1'b0, '0, "R3");
    cpu_op(1'b0, 8'h05, '0, 1'b1, 32'hD2D2_0002, "R3");
    // R6: replacing the Exclusive line writes back first
    push_exp(2'd3, 8'h05, 32'hD2D2_0002, "R6");
    push_exp(2'd1, 8'h09, '0, "R6");
    cpu_op(1'b0, 8'h09, '0, 1'b1, fill(8'h09), "R6");
    // R4: write miss to an Invalid line
    push_exp(2'd2, 8'h02, '0, "R4");
    cpu_op(1'b1, 8'h02, 32'hD3D3_0003, 1'b0, '0, "R4");
    cpu_op(1'b0, 8'h02, '0, 1'b1, 32'hD3D3_0003, "R4");
    // R8: snooped read miss on Exclusive
    snoop(2'd1, 8'h02, 1'b1, 32'hD3D3_0003, "R8");
    cpu_op(1'b0, 8'h02, '0, 1'b1, 32'hD3D3_0003, "R8");
    push_exp(2'd2, 8'h02, '0, "R8");
    cpu_op(1'b1, 8'h02, 32'hD4D4_0004, 1'b0, '0, "R8");
    // R9: snooped write miss on Exclusive
    snoop(2'd2, 8'h02, 1'b1, 32'hD4D4_0004, "R9");
    push_exp(2'd1, 8'h02, '0, "R9");
    cpu_op(1'b0, 8'h02, '0, 1'b1, fill(8'h02), "R9");
    // R7: snoops on Shared line 0x09
    snoop(2'd1, 8'h09, 1'b0, '0, "R7");
    cpu_op(1'b0, 8'h09, '0, 1'b1, fill(8'h09), "R7");
    snoop(2'd2, 8'h0D, 1'b0, '0, "R7");
    cpu_op(1'b0, 8'h09, '0, 1'b1, fill(8'h09), "R7");
    snoop(2'd2, 8'h09, 1'b0, '0, "R7");
    push_exp(2'd1, 8'h09, '0, "R7");
    cpu_op(1'b0, 8'h09, '0, 1'b1, fill(8'h09), "R7");
    // R11: snoop invalidates the line during its lookup
    push_exp(2'd1, 8'h09, '0, "R11");
    cpu_op(1'b0, 8'h09, '0, 1'b1, fill(8'h09), "R11", 1'b1, 2'd2, 8'h09);
    // R6: Shared victim is not written back
    push_exp(2'd2, 8'h06, '0, "R6");
    cpu_op(1'b1, 8'h06, 32'hD5D5_0005, 1'b0, '0, "R6");
    push_exp(2'd3, 8'h06, 32'hD5D5_0005, "R6");
    push_exp(2'd1, 8'h0A, '0, "R6");
    cpu_op(1'b0, 8'h0A, '0, 1'b1, fill(8'h0A), "R6");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end
endmodule